// File: doc/BRIEF.md
# SPI DAC Command Decoder Model

This block is the device side of a serial link that drives a multi-channel digital-to-analog converter. It watches a chip select, a serial clock and a data line and collects 16-bit words, most significant bit first, while chip select is low. When chip select returns high after exactly sixteen serial clock rising edges, the word is decoded into a channel selector, a two-bit command and a left-justified data code. The block then updates a per-channel pending (input) register, a per-channel live (output) register and a shared power-down state.

It is meant as a checking model. A controller under test drives the serial pins, and the bench reads back the live codes, the pending codes and the power-down mode to confirm that the controller sent what it intended. All serial pins are brought into the system clock domain through a synchronizer, so the serial clock must be well below the system clock rate. The number of channels (one to four) and the resolution (8, 10 or 12 bits) are parameters.

Top module: `spi_dac_cmd_model`

## Requirements
- R1: A frame bit 15 down to 0 is decoded as selector = bits 15:14, command = bits 13:12 and data = bits 11:0. The code stored is the top RES bits of the data field (bits 11 down to 12-RES), and lower data bits are ignored.
- R2: Command 00 writes the code into the selected channel's pending register only. Every live register keeps its value.
- R3: Command 01 writes the code into the selected channel's pending and live registers. Other channels' pending and live registers keep their values.
- R4: Command 10 writes the code into the pending and live registers of every channel at once, whatever the selector holds.
- R5: Command 11 with selector 1, 2 or 3 sets pd_mode to that value (1 = 2.5 kilohm to ground, 2 = 100 kilohm to ground, 3 = high impedance) and leaves all codes unchanged. Command 11 with selector 0 changes nothing.
- R6: Commands 01 (on an existing channel) and 10 return pd_mode to 0, which is normal drive. Command 00 leaves pd_mode as it is.
- R7: A frame is acted on only if chip select rises after exactly 16 serial clock rising edges. With any other count, no register changes.
- R8: Commands 00 and 01 whose selector is not below NUM_CH change nothing.
- R9: After reset, all pending and live codes are zero and pd_mode is 0.
- R10: When chip select rises between two system clock edges, the effect of the frame appears right after the fourth following rising clk edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| spi_cs_n | input | 1 | Active-low chip select that frames a word |
| spi_mosi | input | 1 | Serial data, most significant bit first |
| out_code | output | NUM_CH*RES | Live codes; channel i at bits i*RES +: RES |
| pend_code | output | NUM_CH*RES | Pending codes; same packing as out_code |
| pd_mode | output | 2 | 0 = normal drive, 1..3 = power-down mode |

## Verification
Every result of a frame is due on the fourth rising clk edge after chip select rises. Of these, two edges are for the synchronizer, one registers the completed word and one registers the bank. After each frame, the bench holds chip select high for eight cycles before it compares every output with its model. One scenario samples on the falling clk edge right before and right after the fourth edge, which pins the latency. All stimulus changes and all samples fall on falling clk edges, away from the edge where the design registers.

// File: rtl/dacm_pkg.sv
package dacm_pkg;

    localparam int FRAME_BITS = 16;
    localparam int DATA_BITS  = 12;

    typedef enum logic [1:0] {
        OP_LOAD     = 2'b00,
        OP_LOAD_UPD = 2'b01,
        OP_LOAD_ALL = 2'b10,
        OP_PWRDN    = 2'b11
    } dacm_op_e;

    typedef struct packed {
        logic [1:0]           sel;
        dacm_op_e             op;
        logic [DATA_BITS-1:0] data;
    } dacm_frame_t;

endpackage

// File: rtl/dacm_pin_sync.sv
module dacm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic cs_n_raw,
    input  logic mosi_raw,
    output logic sclk_rise,
    output logic cs_rise,
    output logic cs_fall,
    output logic cs_low,
    output logic mosi_s
);
    // bit 0 = sclk, bit 1 = cs_n, bit 2 = mosi
    localparam logic [2:0] IDLE_PINS = 3'b010;
    localparam int         DEPTH     = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][2:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic [2:0] cur, prv;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[DEPTH-2:0], {mosi_raw, cs_n_raw, sclk_raw}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.pipe <= {DEPTH{IDLE_PINS}};
        else        st_q      <= st_d;
    end

    assign cur       = st_q.pipe[STAGES-1];
    assign prv       = st_q.pipe[STAGES];
    assign sclk_rise = cur[0] & ~prv[0];
    assign cs_rise   = cur[1] & ~prv[1];
    assign cs_fall   = ~cur[1] & prv[1];
    assign cs_low    = ~cur[1];
    assign mosi_s    = cur[2];

    a_r10_cs_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |-> $past(cs_low));

endmodule

// File: rtl/dacm_frame_rx.sv
module dacm_frame_rx #(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_rise,
    input  logic                  cs_rise,
    input  logic                  cs_fall,
    input  logic                  cs_low,
    input  logic                  mosi_s,
    output logic                  frame_vld,
    output logic [FRAME_BITS-1:0] frame
);
    localparam int              CNT_W   = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
        logic                  vld;
        logic [FRAME_BITS-1:0] word;
    } rx_st_t;

    rx_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (cs_fall) begin
            st_d.cnt = '0;
        end else if (sclk_rise && cs_low) begin
            st_d.shreg = {st_q.shreg[FRAME_BITS-2:0], mosi_s};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (cs_rise) begin
            st_d.vld  = (st_q.cnt == CNT_OK);
            st_d.word = st_q.shreg;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_vld = st_q.vld;
    assign frame     = st_q.word;

    a_r7_exact_count: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> $past(st_q.cnt) == CNT_OK);

    a_r7_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_SAT);

endmodule

// File: rtl/dacm_reg_bank.sv
module dacm_reg_bank
    import dacm_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_vld,
    input  logic [FRAME_BITS-1:0] frame,
    output logic [NUM_CH*RES-1:0] out_flat,
    output logic [NUM_CH*RES-1:0] pend_flat,
    output logic [1:0]            pd_mode
);
    localparam int LSB = DATA_BITS - RES;

    typedef struct packed {
        logic [NUM_CH-1:0][RES-1:0] pend;
        logic [NUM_CH-1:0][RES-1:0] live;
        logic [1:0]                 pd;
    } bank_st_t;

    bank_st_t    st_d, st_q;
    dacm_frame_t f;
    dacm_op_e    op;
    logic [1:0]  sel;
    logic [RES-1:0] code;
    logic        ch_ok;

    assign f    = dacm_frame_t'(frame);
    assign op   = f.op;
    assign sel  = f.sel;
    assign code = f.data[DATA_BITS-1 -: RES];

    generate
        if (LSB > 0) begin : g_drop_lsbs
            logic unused_lsbs;
            assign unused_lsbs = ^f.data[LSB-1:0];
        end
    endgenerate

    always_comb begin
        ch_ok = (int'(sel) < NUM_CH);
        st_d  = st_q;
        if (frame_vld) begin
            unique case (op)
                OP_LOAD: begin
                    for (int i = 0; i < NUM_CH; i++)
                        if (int'(sel) == i) st_d.pend[i] = code;
                end
                OP_LOAD_UPD: begin
                    for (int i = 0; i < NUM_CH; i++)
                        if (int'(sel) == i) begin
                            st_d.pend[i] = code;
                            st_d.live[i] = code;
                        end
                    if (ch_ok) st_d.pd = 2'd0;
                end
                OP_LOAD_ALL: begin
                    for (int i = 0; i < NUM_CH; i++) begin
                        st_d.pend[i] = code;
                        st_d.live[i] = code;
                    end
                    st_d.pd = 2'd0;
                end
                OP_PWRDN: begin
                    if (sel != 2'd0) st_d.pd = sel;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_flat  = st_q.live;
    assign pend_flat = st_q.pend;
    assign pd_mode   = st_q.pd;

    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(st_q));

    a_r2_load_keeps_live: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && op == OP_LOAD |=> $stable(st_q.live) && $stable(st_q.pd));

    a_r4_all_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && op == OP_LOAD_ALL |=> st_q.live == st_q.pend);

    a_r5_pd_enter: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && op == OP_PWRDN && sel != 2'd0 |=> pd_mode == $past(sel) && $stable(st_q.live));

    a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && ((op == OP_LOAD_UPD && ch_ok) || op == OP_LOAD_ALL) |=> pd_mode == 2'd0);

    a_r8_bad_channel: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld && (op == OP_LOAD || op == OP_LOAD_UPD) && !ch_ok |=> $stable(st_q));

endmodule

// File: rtl/spi_dac_cmd_model.sv
module spi_dac_cmd_model #(
    parameter int NUM_CH = 4,
    parameter int RES    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic [NUM_CH*RES-1:0] out_code,
    output logic [NUM_CH*RES-1:0] pend_code,
    output logic [1:0]            pd_mode
);
    import dacm_pkg::*;

    logic sclk_rise, cs_rise, cs_fall, cs_low, mosi_s;
    logic frame_vld;
    logic [FRAME_BITS-1:0] frame;

    dacm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_raw  (spi_sclk),
        .cs_n_raw  (spi_cs_n),
        .mosi_raw  (spi_mosi),
        .sclk_rise (sclk_rise),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .cs_low    (cs_low),
        .mosi_s    (mosi_s)
    );

    dacm_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .cs_low    (cs_low),
        .mosi_s    (mosi_s),
        .frame_vld (frame_vld),
        .frame     (frame)
    );

    dacm_reg_bank #(.NUM_CH(NUM_CH), .RES(RES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_vld (frame_vld),
        .frame     (frame),
        .out_flat  (out_code),
        .pend_flat (pend_code),
        .pd_mode   (pd_mode)
    );

endmodule

// File: tb/tb_spi_dac_cmd_model.sv
module tb_spi_dac_cmd_model;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;

    logic [47:0] a_out, a_pend;
    logic [1:0]  a_pd;
    logic [15:0] b_out, b_pend;
    logic [1:0]  b_pd;

    int checks = 0;
    int fails  = 0;

    int exp_out[4], exp_pend[4], exp_pd;
    int eb_out[2],  eb_pend[2],  eb_pd;

    always #5 clk = ~clk;

    spi_dac_cmd_model #(.NUM_CH(4), .RES(12)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .out_code(a_out), .pend_code(a_pend), .pd_mode(a_pd));

    spi_dac_cmd_model #(.NUM_CH(2), .RES(8)) dut_b (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .out_code(b_out), .pend_code(b_pend), .pd_mode(b_pd));

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 4; i++) begin
            check(req, $sformatf("A live%0d", i), int'(a_out[i*12 +: 12]), exp_out[i]);
            check(req, $sformatf("A pend%0d", i), int'(a_pend[i*12 +: 12]), exp_pend[i]);
        end
        check(req, "A pd", int'(a_pd), exp_pd);
        for (int i = 0; i < 2; i++) begin
            check(req, $sformatf("B live%0d", i), int'(b_out[i*8 +: 8]), eb_out[i]);
            check(req, $sformatf("B pend%0d", i), int'(b_pend[i*8 +: 8]), eb_pend[i]);
        end
        check(req, "B pd", int'(b_pd), eb_pd);
    endtask

    // expected effect of one well-formed frame, from R1..R8
    task automatic model(input logic [15:0] w);
        int sel, op, ca, cb;
        sel = int'(w[15:14]);
        op  = int'(w[13:12]);
        ca  = int'(w[11:0]);
        cb  = int'(w[11:4]);
        case (op)
            0: begin
                exp_pend[sel] = ca;
                if (sel < 2) eb_pend[sel] = cb;
            end
            1: begin
                exp_pend[sel] = ca; exp_out[sel] = ca; exp_pd = 0;
                if (sel < 2) begin eb_pend[sel] = cb; eb_out[sel] = cb; eb_pd = 0; end
            end
            2: begin
                for (int i = 0; i < 4; i++) begin exp_pend[i] = ca; exp_out[i] = ca; end
                for (int i = 0; i < 2; i++) begin eb_pend[i] = cb; eb_out[i] = cb; end
                exp_pd = 0; eb_pd = 0;
            end
            default: begin
                if (sel != 0) begin exp_pd = sel; eb_pd = sel; end
            end
        endcase
    endtask

    task automatic shift_bits(input logic [31:0] w, input int nbits, input int post);
        cs_n = 1'b0;
        tick(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = w[i];
            tick(3);
            sclk = 1'b1;
            tick(3);
            sclk = 1'b0;
        end
        tick(3);
        cs_n = 1'b1;
        tick(post);
    endtask

    task automatic send(input logic [1:0] sel, input logic [1:0] op, input logic [11:0] data);
        logic [15:0] w;
        w = {sel, op, data};
        shift_bits({16'h0, w}, 16, 8);
        model(w);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin exp_out[i] = 0; exp_pend[i] = 0; end
        for (int i = 0; i < 2; i++) begin eb_out[i] = 0; eb_pend[i] = 0; end
        exp_pd = 0; eb_pd = 0;
        check_all("R9");
    endtask

    task automatic t_load_only;
        send(2'd1, 2'b00, 12'hABC);   // R2: pending only
        check_all("R2");
        send(2'd2, 2'b00, 12'h3C5);
        check_all("R2");
    endtask

    task automatic t_load_update;
        send(2'd0, 2'b01, 12'h123);   // R3: ch1/ch2 pending must survive
        check_all("R3");
        send(2'd1, 2'b01, 12'hFFF);   // R1: B keeps top 8 bits, FF
        check_all("R1");
        send(2'd3, 2'b01, 12'h80F);   // R8: channel 3 absent on B
        check_all("R8");
        send(2'd2, 2'b00, 12'h0F0);   // R8: channel 2 absent on B
        check_all("R8");
    endtask

    task automatic t_broadcast;
        send(2'd3, 2'b10, 12'h5A7);
        check_all("R4");
    endtask

    task automatic t_powerdown;
        send(2'd2, 2'b11, 12'hFFF);
        check_all("R5");
        send(2'd0, 2'b11, 12'h000);   // selector 0: no change
        check_all("R5");
        send(2'd3, 2'b11, 12'h000);
        check_all("R5");
        send(2'd1, 2'b00, 12'h246);   // R6: load-only keeps power-down
        check_all("R6");
        send(2'd1, 2'b01, 12'h246);   // R6: update wakes
        check_all("R6");
        send(2'd1, 2'b11, 12'h000);
        check_all("R5");
        send(2'd0, 2'b10, 12'h9D1);   // R6: broadcast wakes
        check_all("R6");
    endtask

    task automatic t_bad_count;
        shift_bits({17'h0, 2'd1, 2'b01, 12'h777} >> 1, 15, 8);
        check_all("R7");
        shift_bits({15'h0, 2'd1, 2'b01, 12'h777, 1'b1}, 17, 8);
        check_all("R7");
        shift_bits(32'h0, 0, 8);
        check_all("R7");
    endtask

    task automatic t_latency;
        int old_a;
        old_a = exp_out[2];
        shift_bits({16'h0, 2'd2, 2'b01, 12'h6E1}, 16, 3);
        check("R10", "A live2 before 4th edge", int'(a_out[24 +: 12]), old_a);
        tick(1);
        check("R10", "A live2 after 4th edge", int'(a_out[24 +: 12]), 32'h6E1);
        model({2'd2, 2'b01, 12'h6E1});
        tick(4);
        check_all("R10");
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_load_only();
        t_load_update();
        t_broadcast();
        t_powerdown();
        t_bad_count();
        t_latency();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule